// File: doc/BRIEF.md
# Ring Port Insertion Controller

This block is the control state machine of a copper/fiber media-converter port on a token-passing ring. It decides when the port joins the ring (insert state) and when it leaves it (bypass state). It asks a separate key generator to send insertion or bypass keys. It turns on phantom drive where the configuration needs it, drives an active-low "inserted" indicator, and tells the data multiplexer whether to cross-route the traffic (copper to fiber and fiber to copper) or to loop it back.

Two static configurations generate keys. In one, the port qualifies on its two phantom-status lines. In the other, it qualifies on those lines together with optical activity. In both, insertion is a handshake. The qualifying condition must hold for a fixed number of ticks of a slow reference clock. A request for an insertion key then goes out, and the block enters the insert state only if the echo of that key comes back within a second tick window. The two other configurations only react to keys that a key recognizer reports. One of them also drives phantom power while inserted.

All timing runs on a single-cycle `tick` enable derived from the 32.768 kHz reference. With the default limits of 869 and 3277 ticks, the windows are about 26.5 ms and about 100 ms.

Top module: `ring_port_ctrl`

## Requirements
- R1: After synchronous reset the block is in bypass. `inserted_n` is 1, both key requests are 0 and `phantom_en` is 0. `path_cross` is 1 for cfg 1 and cfg 3 and is 0 otherwise. The cfg encoding is: 0 = standard, 1 = concentrator, 2 = lobe port, 3 = ring-in port.
- R2: In cfg 3, both phantom lines must be low on QUAL_TICKS consecutive ticks. `ins_key_req` then pulses for one cycle, one clock after the tick that completes the count. Any phantom line going high resets the count to zero.
- R3: Timers advance only in cycles where `tick` is 1. With `tick` held at 0, no window ever completes.
- R4: After an insertion key request, an `echo_seen` pulse moves the block to insert (`inserted_n` low on the next clock) if it arrives while fewer than ECHO_TICKS ticks have elapsed. This includes the last tick before expiry.
- R5: If ECHO_TICKS ticks elapse without an echo, the block returns to bypass without a bypass key request. A late echo is ignored, and qualification starts again from zero.
- R6: While the block waits for the echo, the phantom lines have no effect.
- R7: In cfg 2 or cfg 3 while inserted, either phantom line going high makes `byp_key_req` pulse for one cycle and `inserted_n` go high on the same clock.
- R8: In cfg 2, qualification also needs `optical_active` high. While inserted, QUAL_TICKS consecutive ticks without optical activity cause the same exit as R7.
- R9: In cfg 0 and cfg 1, `ins_key_seen` moves bypass to insert and `byp_key_seen` moves insert to bypass. The block never requests keys in these configurations, and `wire_fault` has no effect in cfg 0.
- R10: In cfg 1, `phantom_en` is 1 exactly while inserted. `inserted_n` is low only while inserted and `wire_fault` is 0.
- R11: `path_cross` is 1 while inserted and 0 in bypass for cfg 0 and cfg 2. It is always 1 for cfg 1 and cfg 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle enable at the slow reference rate |
| cfg | input | 2 | Port configuration (0 std, 1 concentrator, 2 lobe, 3 ring-in), static outside reset |
| phantom_a | input | 1 | Phantom status line A, high = phantom absent |
| phantom_b | input | 1 | Phantom status line B, high = phantom absent |
| optical_active | input | 1 | Valid optical signal present |
| wire_fault | input | 1 | Phantom wire fault detected |
| ins_key_seen | input | 1 | Pulse: insertion key recognised |
| byp_key_seen | input | 1 | Pulse: bypass key recognised |
| echo_seen | input | 1 | Pulse: insertion key echo recognised |
| ins_key_req | output | 1 | One-cycle request to send an insertion key |
| byp_key_req | output | 1 | One-cycle request to send a bypass key |
| inserted_n | output | 1 | Active-low inserted indicator |
| phantom_en | output | 1 | Enable phantom drive current |
| path_cross | output | 1 | 1 = cross routing, 0 = loopback routing |

## Verification
The bench builds the block with QUAL_TICKS = 6 and ECHO_TICKS = 10, so both windows finish in a few dozen clocks. This lets the bench check the exact clock on which a key request appears, a count restarted by a phantom glitch, an echo that arrives on the final accepted tick and one that arrives after expiry. With `tick` held high, every clock is a tick, and one stretch with `tick` low shows that nothing advances without it.

// File: rtl/ring_port_pkg.sv
package ring_port_pkg;

  typedef enum logic [1:0] {
    CFG_STD  = 2'd0,
    CFG_CONC = 2'd1,
    CFG_LOBE = 2'd2,
    CFG_RING = 2'd3
  } port_cfg_e;

  typedef enum logic [1:0] {
    ST_BYPASS    = 2'd0,
    ST_ECHO_WAIT = 2'd1,
    ST_INSERT    = 2'd2
  } port_state_e;

  function automatic logic cfg_makes_keys(input port_cfg_e c);
    return (c == CFG_LOBE) || (c == CFG_RING);
  endfunction

  function automatic logic cfg_fixed_cross(input port_cfg_e c);
    return (c == CFG_CONC) || (c == CFG_RING);
  endfunction

endpackage

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int LIMIT = 869,
  parameter int W     = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic run,
  input  logic clr,
  output logic done
);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr || !run) begin
      cnt <= '0;
    end else if (tick && cnt != LIM) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done = (cnt == LIM);
endmodule

// File: rtl/port_fsm.sv
module port_fsm
  import ring_port_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  port_cfg_e   cfg,
  input  logic        phantom_hi,
  input  logic        optical_active,
  input  logic        ins_key_seen,
  input  logic        byp_key_seen,
  input  logic        echo_seen,
  input  logic        qual_done,
  input  logic        echo_done,
  output port_state_e state_d,
  output logic        qual_run,
  output logic        echo_run,
  output logic        timers_clr,
  output logic        start_ins,
  output logic        start_byp
);
  port_state_e state_q;
  logic        keygen;
  logic        qual_cond;
  logic        dropout_cond;

  assign keygen       = cfg_makes_keys(cfg);
  assign qual_cond    = !phantom_hi && ((cfg != CFG_LOBE) || optical_active);
  assign dropout_cond = (cfg == CFG_LOBE) && !optical_active;

  always_comb begin
    state_d   = state_q;
    start_ins = 1'b0;
    start_byp = 1'b0;
    unique case (state_q)
      ST_BYPASS: begin
        if (keygen) begin
          if (qual_done) begin
            state_d   = ST_ECHO_WAIT;
            start_ins = 1'b1;
          end
        end else if (ins_key_seen) begin
          state_d = ST_INSERT;
        end
      end
      ST_ECHO_WAIT: begin
        if (!keygen) begin
          state_d = ST_BYPASS;
        end else if (echo_seen && !echo_done) begin
          state_d = ST_INSERT;
        end else if (echo_done) begin
          state_d = ST_BYPASS;
        end
      end
      ST_INSERT: begin
        if (keygen) begin
          if (phantom_hi || ((cfg == CFG_LOBE) && qual_done)) begin
            state_d   = ST_BYPASS;
            start_byp = 1'b1;
          end
        end else if (byp_key_seen) begin
          state_d = ST_BYPASS;
        end
      end
      default: state_d = ST_BYPASS;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_BYPASS;
    end else begin
      state_q <= state_d;
    end
  end

  assign qual_run   = ((state_q == ST_BYPASS) && keygen && qual_cond) ||
                      ((state_q == ST_INSERT) && dropout_cond);
  assign echo_run   = (state_q == ST_ECHO_WAIT);
  assign timers_clr = (state_d != state_q);
endmodule

// File: rtl/port_outputs.sv
module port_outputs
  import ring_port_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  port_cfg_e   cfg,
  input  port_state_e state_d,
  input  logic        wire_fault,
  input  logic        start_ins,
  input  logic        start_byp,
  output logic        ins_key_req,
  output logic        byp_key_req,
  output logic        inserted_n,
  output logic        phantom_en,
  output logic        path_cross
);
  logic in_ins;
  logic fault_hides;

  assign in_ins      = (state_d == ST_INSERT);
  assign fault_hides = (cfg == CFG_CONC) && wire_fault;

  always_ff @(posedge clk) begin
    if (rst) begin
      ins_key_req <= 1'b0;
      byp_key_req <= 1'b0;
      inserted_n  <= 1'b1;
      phantom_en  <= 1'b0;
      path_cross  <= cfg_fixed_cross(cfg);
    end else begin
      ins_key_req <= start_ins;
      byp_key_req <= start_byp;
      inserted_n  <= !(in_ins && !fault_hides);
      phantom_en  <= in_ins && (cfg == CFG_CONC);
      path_cross  <= cfg_fixed_cross(cfg) || in_ins;
    end
  end
endmodule

// File: rtl/ring_port_ctrl.sv
module ring_port_ctrl
  import ring_port_pkg::*;
#(
  parameter int QUAL_TICKS = 869,
  parameter int ECHO_TICKS = 3277
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic [1:0] cfg,
  input  logic       phantom_a,
  input  logic       phantom_b,
  input  logic       optical_active,
  input  logic       wire_fault,
  input  logic       ins_key_seen,
  input  logic       byp_key_seen,
  input  logic       echo_seen,
  output logic       ins_key_req,
  output logic       byp_key_req,
  output logic       inserted_n,
  output logic       phantom_en,
  output logic       path_cross
);
  port_cfg_e   cfg_e;
  port_state_e state_d;
  logic qual_run, echo_run, timers_clr;
  logic qual_done, echo_done;
  logic start_ins, start_byp;

  assign cfg_e = port_cfg_e'(cfg);

  port_fsm u_fsm (
    .clk            (clk),
    .rst            (rst),
    .cfg            (cfg_e),
    .phantom_hi     (phantom_a | phantom_b),
    .optical_active (optical_active),
    .ins_key_seen   (ins_key_seen),
    .byp_key_seen   (byp_key_seen),
    .echo_seen      (echo_seen),
    .qual_done      (qual_done),
    .echo_done      (echo_done),
    .state_d        (state_d),
    .qual_run       (qual_run),
    .echo_run       (echo_run),
    .timers_clr     (timers_clr),
    .start_ins      (start_ins),
    .start_byp      (start_byp)
  );

  tick_timer #(.LIMIT(QUAL_TICKS)) u_qual_tmr (
    .clk  (clk),
    .rst  (rst),
    .tick (tick),
    .run  (qual_run),
    .clr  (timers_clr),
    .done (qual_done)
  );

  tick_timer #(.LIMIT(ECHO_TICKS)) u_echo_tmr (
    .clk  (clk),
    .rst  (rst),
    .tick (tick),
    .run  (echo_run),
    .clr  (timers_clr),
    .done (echo_done)
  );

  port_outputs u_out (
    .clk         (clk),
    .rst         (rst),
    .cfg         (cfg_e),
    .state_d     (state_d),
    .wire_fault  (wire_fault),
    .start_ins   (start_ins),
    .start_byp   (start_byp),
    .ins_key_req (ins_key_req),
    .byp_key_req (byp_key_req),
    .inserted_n  (inserted_n),
    .phantom_en  (phantom_en),
    .path_cross  (path_cross)
  );
endmodule

// File: rtl/ring_port_ctrl_chk.sv
module ring_port_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] cfg,
  input logic       ins_key_req,
  input logic       byp_key_req,
  input logic       inserted_n,
  input logic       phantom_en,
  input logic       path_cross
);
  // R2: an insertion key request lasts exactly one cycle
  a_r2_req_single: assert property (@(posedge clk) disable iff (rst)
    ins_key_req |=> !ins_key_req);

  // R4: the request is issued before insertion, never while inserted
  a_r4_req_before_insert: assert property (@(posedge clk) disable iff (rst)
    ins_key_req |-> inserted_n);

  // R7: a bypass key request comes with the indicator released
  a_r7_byp_released: assert property (@(posedge clk) disable iff (rst)
    byp_key_req |-> inserted_n);

  // R9: passive configurations never request keys
  a_r9_passive_no_keys: assert property (@(posedge clk) disable iff (rst)
    (cfg[1] == 1'b0) |-> (!ins_key_req && !byp_key_req));

  // R10: phantom drive only in the concentrator configuration
  a_r10_phantom_conc: assert property (@(posedge clk) disable iff (rst)
    phantom_en |-> (cfg == 2'd1));

  // R11: an inserted port always cross-routes
  a_r11_inserted_cross: assert property (@(posedge clk) disable iff (rst)
    !inserted_n |-> path_cross);

  // R7: the two key requests never coincide
  a_r7_reqs_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(ins_key_req && byp_key_req));
endmodule

bind ring_port_ctrl ring_port_ctrl_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg         (cfg),
  .ins_key_req (ins_key_req),
  .byp_key_req (byp_key_req),
  .inserted_n  (inserted_n),
  .phantom_en  (phantom_en),
  .path_cross  (path_cross)
);

// File: tb/ring_port_ctrl_test.sv
module ring_port_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 6;
  localparam int E = 10;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b1;
  logic [1:0] cfg = 2'd3;
  logic phan_a = 1'b1, phan_b = 1'b1, opt = 1'b0, fault = 1'b0;
  logic kin = 1'b0, kbyp = 1'b0, echo = 1'b0;
  logic req_ins, req_byp, inserted_n, phantom_en, path_cross;

  int n_checks = 0;
  int n_errors = 0;
  int n_ins = 0;
  int n_byp = 0;
  int cycles = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ring_port_ctrl #(.QUAL_TICKS(Q), .ECHO_TICKS(E)) uut (
    .clk(clk), .rst(rst), .tick(tick), .cfg(cfg),
    .phantom_a(phan_a), .phantom_b(phan_b), .optical_active(opt),
    .wire_fault(fault), .ins_key_seen(kin), .byp_key_seen(kbyp),
    .echo_seen(echo), .ins_key_req(req_ins), .byp_key_req(req_byp),
    .inserted_n(inserted_n), .phantom_en(phantom_en), .path_cross(path_cross)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst) begin
      n_ins <= 0;
      n_byp <= 0;
    end else begin
      if (req_ins) n_ins <= n_ins + 1;
      if (req_byp) n_byp <= n_byp + 1;
    end
  end

  always @(posedge clk) begin
    if (cycles > WATCHDOG) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] c);
    @(negedge clk);
    rst = 1'b1; cfg = c;
    kin = 0; kbyp = 0; echo = 0; fault = 0;
    edges(3);
    rst = 1'b0;
  endtask

  task automatic pulse_echo;
    echo = 1'b1;
    edges(1);
    echo = 1'b0;
  endtask

  task automatic wait_req(input int lim, output logic seen);
    seen = 1'b0;
    for (int k = 0; k < lim && !seen; k++) begin
      edges(1);
      if (req_ins) seen = 1'b1;
    end
  endtask

  // {cfg[1:0], kin, kbyp, fault, exp_inserted_n, exp_phantom_en, exp_path_cross}
  localparam logic [7:0] TBL [0:10] = '{
    8'b01_000_101, 8'b01_100_011, 8'b01_001_111, 8'b01_000_011,
    8'b01_100_011, 8'b01_010_101,
    8'b00_000_100, 8'b00_010_100, 8'b00_100_001, 8'b00_001_001,
    8'b00_010_100
  };

  initial begin
    logic seen;
    phan_a = 0; phan_b = 0;
    for (int i = 0; i < 11; i++) begin
      if (i == 0 || TBL[i][7:6] != TBL[i-1][7:6]) do_reset(TBL[i][7:6]);
      kin = TBL[i][5]; kbyp = TBL[i][4]; fault = TBL[i][3];
      edges(1);
      kin = 0; kbyp = 0;
      chk("R9 R10 inserted_n", int'(inserted_n), int'(TBL[i][2]));
      chk("R10 phantom_en", int'(phantom_en), int'(TBL[i][1]));
      chk("R11 path_cross", int'(path_cross), int'(TBL[i][0]));
    end
    edges(1);
    chk("R9 no key requests", n_ins + n_byp, 0);

    // Ring-in port configuration
    phan_a = 1; phan_b = 1;
    do_reset(2'd3);
    edges(1);
    chk("R1 inserted_n", int'(inserted_n), 1);
    chk("R1 req_ins", int'(req_ins), 0);
    chk("R1 phantom_en", int'(phantom_en), 0);
    chk("R1 path_cross", int'(path_cross), 1);

    tick = 0; phan_a = 0; phan_b = 0;
    edges(20);
    chk("R3 no progress without tick", n_ins, 0);
    tick = 1;

    edges(Q - 1);
    phan_a = 1;
    edges(1);
    phan_a = 0;
    edges(Q);
    chk("R2 count restarted after glitch", n_ins + int'(req_ins), 0);
    edges(1);
    chk("R2 insertion key request", int'(req_ins), 1);

    phan_a = 1; phan_b = 1;
    edges(3);
    chk("R6 phantom ignored in wait", int'(inserted_n), 1);
    chk("R6 no bypass key in wait", n_byp, 0);
    phan_a = 0; phan_b = 0;
    edges(E - 1 - 3);
    pulse_echo();
    chk("R4 echo on last tick inserts", int'(inserted_n), 0);
    chk("R11 ring-in cross", int'(path_cross), 1);

    phan_b = 1;
    edges(1);
    phan_b = 0;
    chk("R7 bypass key request", int'(req_byp), 1);
    chk("R7 indicator released", int'(inserted_n), 1);
    edges(1);
    chk("R7 one bypass key", n_byp, 1);

    wait_req(Q + 4, seen);
    chk("R2 requalified", int'(seen), 1);
    edges(E + 1);
    pulse_echo();
    chk("R5 late echo ignored", int'(inserted_n), 1);
    chk("R5 no bypass key on expiry", n_byp, 1);
    wait_req(Q + 3, seen);
    chk("R5 qualification restarts", int'(seen), 1);

    // Lobe port configuration
    phan_a = 0; phan_b = 0; opt = 0;
    do_reset(2'd2);
    edges(1);
    chk("R11 lobe loopback", int'(path_cross), 0);
    edges(Q + 3);
    chk("R8 no key without optical", n_ins, 0);
    opt = 1;
    edges(Q);
    chk("R8 not before window", int'(req_ins), 0);
    edges(1);
    chk("R8 insertion key request", int'(req_ins), 1);
    pulse_echo();
    chk("R8 inserted", int'(inserted_n), 0);
    chk("R11 lobe cross when inserted", int'(path_cross), 1);
    opt = 0;
    edges(Q);
    chk("R8 still inserted", int'(inserted_n), 0);
    edges(1);
    chk("R8 dropout bypass key", int'(req_byp), 1);
    chk("R8 dropout indicator", int'(inserted_n), 1);
    chk("R11 lobe loopback after dropout", int'(path_cross), 0);

    edges(2);
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule